// File: doc/BRIEF.md
# Quadrature Decoder with Interval Timer

This block turns the two phase-shifted channels of an incremental encoder into position counts, and it measures how much time has passed since the most recent count. Each channel goes through a two-flop synchroniser and a run-length glitch filter. The filtered pair is then decoded in one of two resolutions. In the coarse resolution the block counts once per encoder line. In the fine resolution it counts on every legal edge of either channel.

Each count produces a one-cycle count pulse and a direction bit. A signed position register steps by one on each pulse. A saturating tick counter restarts at every pulse and otherwise counts clock cycles. Across each sampling period the block also collects the net count change, a flag that says whether any count happened, and a flag that says whether the counting direction reversed.

A one-cycle sampling strobe freezes these values into a snapshot record and starts a new period. A downstream velocity stage reads the record. The record is qualified by a valid pulse and has no ready input, so the consumer cannot apply back-pressure. The consumer must take each record in the cycle its valid pulse is high, because the next strobe overwrites it.

Top module: `qdec_stamp`

## Requirements
- R1: Each channel is synchronised by two flops and then filtered. A level change is accepted only after it has persisted for FILT_N consecutive cycles, so a change that is shorter than this has no effect on any count.
- R2: In fine mode (`x4_mode`=1), every change of exactly one channel produces one count. With the state written as {A,B}, the order 00→10→11→01→00 counts up and the reverse order counts down.
- R3: In coarse mode (`x4_mode`=0), counts happen only when A rises while B is unchanged. The count is up when B is 0 and down when B is 1. No other edge produces a count.
- R4: A filtered change of both channels in the same cycle is illegal and produces no count. The new state becomes the reference for the next change.
- R5: `pos_count` increases by one after a pulse with `cnt_dir`=1, decreases by one after a pulse with `cnt_dir`=0, and is otherwise unchanged.
- R6: `elapsed` is 0 in the cycle after a count pulse and otherwise rises by one per clock.
- R7: `elapsed` stops at its all-ones value and does not wrap.
- R8: `snap_vld` is high for exactly the one cycle after each `samp_stb`. In that cycle `snap_delta` holds the signed net count since the previous strobe and `snap_ticks` holds the `elapsed` value of the strobe cycle. The snapshot fields change only after a strobe.
- R9: `snap_seen` is 1 exactly when at least one count fell inside the period.
- R10: `snap_rev` is 1 exactly when some count in the period had the opposite direction to the count before it. That earlier count may belong to a previous period. The first count after reset is never a reversal.
- R11: A count pulse that coincides with the strobe cycle is assigned to the new period. In that case `snap_ticks` holds the value before the restart.
- R12: During reset, `pos_count`, `elapsed`, `cnt_pulse` and `snap_vld` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| x4_mode | input | 1 | 1 selects fine (four counts per line), 0 selects coarse (one count per line) |
| samp_stb | input | 1 | One-cycle sampling strobe |
| cnt_pulse | output | 1 | One-cycle count pulse |
| cnt_dir | output | 1 | Direction of the latest count, 1 means up |
| pos_count | output | POS_W | Signed running position |
| elapsed | output | TICK_W | Clock ticks since the latest count, saturating |
| snap_vld | output | 1 | Snapshot valid, one cycle after the strobe |
| snap_delta | output | DELTA_W | Signed net count of the closed period |
| snap_ticks | output | TICK_W | Elapsed ticks at the strobe |
| snap_seen | output | 1 | A count occurred in the closed period |
| snap_rev | output | 1 | The direction reversed in the closed period |

## Verification
The bench aims a strobe at the exact cycle in which a count pulse lands. A design that assigned that pulse to the closing period would report a delta that is one too large, followed by a next delta that is one too small. It drives a one-cycle glitch on A and a simultaneous change of both channels. A missing filter or a missing legality check would show up as spurious counts in the snapshot. It runs the coarse and fine decoders forward and backward to catch swapped directions or counts on the wrong edge, and it stays idle for longer than the tick range, which exposes a counter that wraps instead of holding at all-ones. Reversal detection is checked at period boundaries, where a design that forgot the previous period's direction would miss the flag.

// File: rtl/qts_pkg.sv
package qts_pkg;

  // Channel pair state, written {A,B}
  typedef logic [1:0] ab_t;

  // True when cur follows prev in the up-counting Gray order
  function automatic logic step_is_up(ab_t prev, ab_t cur);
    logic r;
    case ({prev, cur})
      4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: r = 1'b1;
      default:                                r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/qts_infilt.sv
module qts_infilt #(
  parameter int FILT_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);

  localparam int CW = (FILT_N < 2) ? 1 : $clog2(FILT_N);
  localparam logic [CW-1:0] LAST = CW'(FILT_N - 1);

  logic          s1, s2;
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      clean <= 1'b0;
      run   <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == clean) begin
        run <= '0;
      end else if (run == LAST) begin
        clean <= s2;
        run   <= '0;
      end else begin
        run <= run + CW'(1);
      end
    end
  end

endmodule

// File: rtl/qts_decode.sv
module qts_decode
  import qts_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ab_t  ab,
  input  logic x4_mode,
  output logic pulse,
  output logic up
);

  ab_t  ab_q;
  ab_t  chg;
  logic ev;
  logic ev_up;

  always_comb begin
    chg   = ab ^ ab_q;
    ev    = 1'b0;
    ev_up = 1'b0;
    if (x4_mode) begin
      if (chg == 2'b01 || chg == 2'b10) begin
        ev    = 1'b1;
        ev_up = step_is_up(ab_q, ab);
      end
    end else begin
      if (chg == 2'b10 && ab[1]) begin
        ev    = 1'b1;
        ev_up = ~ab[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ab_q  <= 2'b00;
      pulse <= 1'b0;
      up    <= 1'b0;
    end else begin
      ab_q  <= ab;
      pulse <= ev;
      if (ev) up <= ev_up;
    end
  end

endmodule

// File: rtl/qts_track.sv
module qts_track #(
  parameter int POS_W   = 32,
  parameter int TICK_W  = 16,
  parameter int DELTA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pulse,
  input  logic                      up,
  input  logic                      samp_stb,
  output logic signed [POS_W-1:0]   pos_count,
  output logic        [TICK_W-1:0]  elapsed,
  output logic                      snap_vld,
  output logic signed [DELTA_W-1:0] snap_delta,
  output logic        [TICK_W-1:0]  snap_ticks,
  output logic                      snap_seen,
  output logic                      snap_rev
);

  localparam logic [TICK_W-1:0]        TMAX  = '1;
  localparam logic signed [POS_W-1:0]  P_ONE = POS_W'(1);
  localparam logic signed [DELTA_W-1:0] D_ONE = DELTA_W'(1);

  logic signed [DELTA_W-1:0] per_delta;
  logic signed [DELTA_W-1:0] step;
  logic                      per_seen, per_rev;
  logic                      last_up, have_dir;
  logic                      rev_now;

  always_comb begin
    step    = pulse ? (up ? D_ONE : -D_ONE) : '0;
    rev_now = pulse && have_dir && (up != last_up);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_count <= '0;
      elapsed   <= '0;
      last_up   <= 1'b0;
      have_dir  <= 1'b0;
    end else begin
      if (pulse) begin
        pos_count <= up ? pos_count + P_ONE : pos_count - P_ONE;
        elapsed   <= '0;
        last_up   <= up;
        have_dir  <= 1'b1;
      end else if (elapsed != TMAX) begin
        elapsed <= elapsed + TICK_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_delta  <= '0;
      per_seen   <= 1'b0;
      per_rev    <= 1'b0;
      snap_vld   <= 1'b0;
      snap_delta <= '0;
      snap_ticks <= '0;
      snap_seen  <= 1'b0;
      snap_rev   <= 1'b0;
    end else if (samp_stb) begin
      snap_vld   <= 1'b1;
      snap_delta <= per_delta;
      snap_ticks <= elapsed;
      snap_seen  <= per_seen;
      snap_rev   <= per_rev;
      per_delta  <= step;
      per_seen   <= pulse;
      per_rev    <= rev_now;
    end else begin
      snap_vld  <= 1'b0;
      per_delta <= per_delta + step;
      per_seen  <= per_seen | pulse;
      per_rev   <= per_rev | rev_now;
    end
  end

endmodule

// File: rtl/qdec_stamp.sv
module qdec_stamp
  import qts_pkg::*;
#(
  parameter int FILT_N  = 3,
  parameter int POS_W   = 32,
  parameter int TICK_W  = 16,
  parameter int DELTA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enc_a,
  input  logic                      enc_b,
  input  logic                      x4_mode,
  input  logic                      samp_stb,
  output logic                      cnt_pulse,
  output logic                      cnt_dir,
  output logic signed [POS_W-1:0]   pos_count,
  output logic        [TICK_W-1:0]  elapsed,
  output logic                      snap_vld,
  output logic signed [DELTA_W-1:0] snap_delta,
  output logic        [TICK_W-1:0]  snap_ticks,
  output logic                      snap_seen,
  output logic                      snap_rev
);

  ab_t raw_ab;
  ab_t clean_ab;

  assign raw_ab = {enc_a, enc_b};

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    qts_infilt #(.FILT_N(FILT_N)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_ab[ch]),
      .clean (clean_ab[ch])
    );
  end

  qts_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .ab      (clean_ab),
    .x4_mode (x4_mode),
    .pulse   (cnt_pulse),
    .up      (cnt_dir)
  );

  qts_track #(
    .POS_W   (POS_W),
    .TICK_W  (TICK_W),
    .DELTA_W (DELTA_W)
  ) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse      (cnt_pulse),
    .up         (cnt_dir),
    .samp_stb   (samp_stb),
    .pos_count  (pos_count),
    .elapsed    (elapsed),
    .snap_vld   (snap_vld),
    .snap_delta (snap_delta),
    .snap_ticks (snap_ticks),
    .snap_seen  (snap_seen),
    .snap_rev   (snap_rev)
  );

endmodule

// File: rtl/qts_check.sv
module qts_check #(
  parameter int POS_W   = 32,
  parameter int TICK_W  = 16,
  parameter int DELTA_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      samp_stb,
  input logic                      cnt_pulse,
  input logic                      cnt_dir,
  input logic signed [POS_W-1:0]   pos_count,
  input logic        [TICK_W-1:0]  elapsed,
  input logic                      snap_vld,
  input logic signed [DELTA_W-1:0] snap_delta,
  input logic        [TICK_W-1:0]  snap_ticks
);

  localparam logic [TICK_W-1:0] TMAX = '1;

  AST_POS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pulse && cnt_dir) |=> (pos_count == $past(pos_count) + POS_W'(1))); // R5
  AST_POS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pulse && !cnt_dir) |=> (pos_count == $past(pos_count) - POS_W'(1))); // R5
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_pulse |=> $stable(pos_count)); // R5
  AST_TICK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |=> (elapsed == '0)); // R6
  AST_TICK_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_pulse && elapsed == TMAX) |=> (elapsed == TMAX)); // R7
  AST_SNAP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb |=> snap_vld); // R8
  AST_SNAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_stb |=> (!snap_vld && $stable(snap_delta) && $stable(snap_ticks))); // R8

endmodule

bind qdec_stamp qts_check #(
  .POS_W   (POS_W),
  .TICK_W  (TICK_W),
  .DELTA_W (DELTA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .samp_stb   (samp_stb),
  .cnt_pulse  (cnt_pulse),
  .cnt_dir    (cnt_dir),
  .pos_count  (pos_count),
  .elapsed    (elapsed),
  .snap_vld   (snap_vld),
  .snap_delta (snap_delta),
  .snap_ticks (snap_ticks)
);

// File: tb/sim_qdec_stamp.sv
`timescale 1ns/1ps
module sim_qdec_stamp;

  localparam int FILT = 2;
  localparam int PW   = 32;
  localparam int TW   = 8;
  localparam int DW   = 16;
  localparam int TMAX = (1 << TW) - 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 enc_a = 1'b0, enc_b = 1'b0;
  logic                 x4_mode = 1'b1;
  logic                 samp_stb = 1'b0;
  logic                 cnt_pulse, cnt_dir;
  logic signed [PW-1:0] pos_count;
  logic [TW-1:0]        elapsed;
  logic                 snap_vld;
  logic signed [DW-1:0] snap_delta;
  logic [TW-1:0]        snap_ticks;
  logic                 snap_seen, snap_rev;

  qdec_stamp #(.FILT_N(FILT), .POS_W(PW), .TICK_W(TW), .DELTA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .x4_mode(x4_mode), .samp_stb(samp_stb),
    .cnt_pulse(cnt_pulse), .cnt_dir(cnt_dir), .pos_count(pos_count),
    .elapsed(elapsed), .snap_vld(snap_vld), .snap_delta(snap_delta),
    .snap_ticks(snap_ticks), .snap_seen(snap_seen), .snap_rev(snap_rev)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    delta;
    int    ticks;
    bit    seen;
    bit    rev;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   ev_eff[$];
  bit   ev_up[$];

  int       n_chk = 0, n_fail = 0;
  int       m_delta = 0, last_eff = 0, exp_pos = 0;
  bit       m_seen = 0, m_rev = 0, m_last_up = 0, m_have = 0;
  bit [1:0] cur_ab = 2'b00;
  bit       done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit fwd(bit [1:0] p, bit [1:0] c);
    return (p == 2'b00 && c == 2'b10) || (p == 2'b10 && c == 2'b11) ||
           (p == 2'b11 && c == 2'b01) || (p == 2'b01 && c == 2'b00);
  endfunction

  // Driver: change the pins, and predict from the requirement rules whether a count results
  task automatic drv(bit [1:0] nab);
    bit [1:0] chg;
    bit ev, up;
    @(negedge clk);
    {enc_a, enc_b} = nab;
    chg = nab ^ cur_ab;
    ev = 0; up = 0;
    if (x4_mode) begin
      if (chg == 2'b01 || chg == 2'b10) begin ev = 1; up = fwd(cur_ab, nab); end
    end else if (chg == 2'b10 && nab[1]) begin
      ev = 1; up = !nab[0];
    end
    if (ev) begin
      ev_eff.push_back(cyc + 1 + 3 + FILT);
      ev_up.push_back(up);
      exp_pos += up ? 1 : -1;
    end
    cur_ab = nab;
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic walk(bit [1:0] s0, bit [1:0] s1, bit [1:0] s2, bit [1:0] s3);
    drv(s0); gap(10); drv(s1); gap(10); drv(s2); gap(10); drv(s3); gap(10);
  endtask

  // Strobe: close the period in the model and push the expected record
  task automatic strobe(string tag);
    int s;
    exp_t e;
    @(negedge clk);
    samp_stb = 1'b1;
    s = cyc + 1;
    while (ev_eff.size() > 0 && ev_eff[0] < s) begin
      int  eff;
      bit  up;
      eff = ev_eff.pop_front();
      up  = ev_up.pop_front();
      m_delta += up ? 1 : -1;
      m_seen = 1;
      if (m_have && up != m_last_up) m_rev = 1;
      m_last_up = up;
      m_have = 1;
      last_eff = eff;
    end
    e.delta = m_delta;
    e.ticks = (s - 1 - last_eff > TMAX) ? TMAX : s - 1 - last_eff;
    e.seen  = m_seen;
    e.rev   = m_rev;
    e.tag   = tag;
    sb.push_back(e);
    m_delta = 0; m_seen = 0; m_rev = 0;
    @(negedge clk);
    samp_stb = 1'b0;
  endtask

  // Monitor: pop and compare each snapshot as it appears
  always @(negedge clk) begin
    if (rst_n && snap_vld) begin
      if (sb.size() == 0) begin
        chk(0, "R8 unexpected snapshot", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(int'(snap_delta) == e.delta, {e.tag, " R8 delta"}, int'(snap_delta), e.delta);
        chk(int'(snap_ticks) == e.ticks, {e.tag, " R6 ticks"}, int'(snap_ticks), e.ticks);
        chk(snap_seen == e.seen, {e.tag, " R9 seen"}, int'(snap_seen), int'(e.seen));
        chk(snap_rev == e.rev, {e.tag, " R10 rev"}, int'(snap_rev), int'(e.rev));
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    gap(5);
    chk(pos_count == 0, "R12 pos_count", int'(pos_count), 0);
    chk(elapsed == 0, "R12 elapsed", int'(elapsed), 0);
    chk(cnt_pulse == 0, "R12 cnt_pulse", int'(cnt_pulse), 0);
    chk(snap_vld == 0, "R12 snap_vld", int'(snap_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    last_eff = cyc;
    gap(20);

    // Fine mode, forward then backward (the first backward count is a reversal)
    walk(2'b10, 2'b11, 2'b01, 2'b00);
    strobe("R2 fine up");
    gap(5);
    walk(2'b01, 2'b11, 2'b10, 2'b00);
    strobe("R2 fine down");
    gap(7);
    strobe("R9 empty period");
    gap(5);

    // Coarse mode, one count per full cycle in each direction
    x4_mode = 1'b0;
    walk(2'b10, 2'b11, 2'b01, 2'b00);
    strobe("R3 coarse up");
    gap(5);
    walk(2'b01, 2'b11, 2'b10, 2'b00);
    strobe("R3 coarse down");
    gap(5);
    x4_mode = 1'b1;
    gap(5);

    // A change of both channels at once is illegal; the new state is the reference
    drv(2'b11); gap(12);
    strobe("R4 illegal step");
    gap(5);
    drv(2'b01); gap(10); drv(2'b00); gap(10);
    strobe("R4 after illegal");
    gap(5);

    // A one-cycle glitch on A, shorter than the filter
    @(negedge clk); enc_a = 1'b1;
    @(negedge clk); enc_a = 1'b0;
    gap(12);
    strobe("R1 glitch");
    gap(5);

    // A count pulse that lands in the strobe cycle
    drv(2'b10);
    gap(2 + FILT);
    strobe("R11 coincident close");
    gap(9);
    strobe("R11 coincident next");
    gap(5);

    // A long idle stretch: the tick counter saturates
    gap(TMAX + 40);
    strobe("R7 saturate");
    chk(int'(elapsed) == TMAX, "R7 elapsed live", int'(elapsed), TMAX);
    drv(2'b11); gap(12);
    strobe("R6 restart");

    gap(10);
    chk(int'(pos_count) == exp_pos, "R5 pos_count", int'(pos_count), exp_pos);
    chk(sb.size() == 0, "R8 pending snapshots", sb.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule